// File: doc/BRIEF.md
# Reorder Buffer with Multi-Cycle Squash Walk

This block keeps the in-flight instructions of an out-of-order core in program order inside a circular buffer. Each slot holds a sequence number, a PC and a next-PC, plus a completion flag and a squash flag. Dispatch pushes one instruction per cycle into the youngest position over a valid/ready stream. The oldest slot is exposed at the head outputs. When that slot has been marked complete, a retire strobe frees it. Full, empty and the number of free slots are reported every cycle. The capacity must be a power of two.

On a misprediction the core presents a flush request with the sequence number of the faulting instruction. The block then walks from the youngest slot toward the oldest. It flags every slot whose sequence number is younger than the key, and it inspects at most a fixed number of slots per cycle. While the walk runs, flagged slots stay allocated and the youngest pointer does not move. In the cycle the walk meets an instruction that is not younger, or runs out of slots, the youngest pointer and the occupancy drop together and release the flagged slots.

Back-pressure works as follows. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the buffer is full or a walk is in progress. A producer that raises `in_valid` while the buffer is full sees `in_overrun` for that cycle, and nothing is written.

Top module: `rob_incr_squash`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `hd_ready`=0, `flush_idle`=1. `full` is 1 exactly when the occupancy equals the capacity, and `empty` is 1 exactly when the occupancy is zero.
- R2: `free_cnt` equals the capacity minus the occupancy. An accepted insert lowers it by one and an accepted retire raises it by one. Both in one cycle leave it unchanged.
- R3: `in_ready` is 1 exactly when the buffer is not full and no walk is in progress. An accepted instruction lands in slot `in_slot` and becomes the youngest entry, so `tl_seq`/`tl_pc` show it on the next cycle.
- R4: `in_overrun` is 1 in any cycle where `in_valid` is 1 while `full` is 1. The buffer contents are not changed by that request.
- R5: While the buffer is not empty, `hd_seq`, `hd_pc` and `hd_npc` show the oldest entry. Their values carry no meaning while the buffer is empty.
- R6: `hd_ready` is 1 exactly when the buffer is not empty, the head entry has been marked complete via `done_valid`/`done_slot`, and no walk is in progress. `hd_retire` while `hd_ready` is 1 frees the head. `hd_retire` at any other time has no effect.
- R7: A flush request taken while `flush_idle` is 1 starts a walk. During the walk, `tl_seq`, `tl_pc` and `free_cnt` stay constant.
- R8: `flush_idle` goes low on the edge that accepts the flush and returns high on the edge where the walk ends. A flush request made while low is ignored.
- R9: Each walk cycle inspects at most SQ_WIDTH entries, starting from the youngest not yet inspected. The walk ends in the first cycle that finds an entry not younger than the key, or that inspects the oldest entry.
- R10: When the walk ends, every entry younger than the key is released at once. The youngest remaining entry becomes the tail, and occupancy drops by the number released.
- R11: "Younger than the key" means that the SEQ_W-bit difference (entry minus key), read as a signed number, is greater than zero. Ordering therefore stays correct across counter wrap.
- R12: An insert or a retire accepted on the same edge as a flush is applied first. The walk then covers the buffer including the new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Dispatch offers an instruction |
| in_ready | output | 1 | Buffer can take an instruction this cycle |
| in_seq | input | SEQ_W | Sequence number of the offered instruction |
| in_pc | input | PC_W | PC of the offered instruction |
| in_npc | input | PC_W | Next-PC of the offered instruction |
| in_slot | output | IDX_W | Slot the next accepted instruction will occupy |
| in_overrun | output | 1 | Insert offered while full (protocol error) |
| done_valid | input | 1 | Mark a slot complete |
| done_slot | input | IDX_W | Slot to mark complete |
| hd_ready | output | 1 | Head entry may retire |
| hd_retire | input | 1 | Retire the head entry |
| hd_seq | output | SEQ_W | Head sequence number |
| hd_pc | output | PC_W | Head PC |
| hd_npc | output | PC_W | Head next-PC |
| tl_seq | output | SEQ_W | Youngest entry sequence number |
| tl_pc | output | PC_W | Youngest entry PC |
| full | output | 1 | Occupancy equals capacity |
| empty | output | 1 | Occupancy is zero |
| free_cnt | output | CNT_W | Capacity minus occupancy |
| flush_req | input | 1 | Start a squash walk |
| flush_seq | input | SEQ_W | Sequence number of the faulting instruction |
| flush_idle | output | 1 | No squash walk in progress |

## Verification
A flush request can land on the same edge as an accepted insert, and also on the same edge as a head retire. This happens often because the stimulus raises inserts, retires and flushes independently in every cycle, and it picks keys that select all entries, none, or a random middle entry. The behavioural model applies the retire and the insert before it starts the walk. Each cycle it compares the tail, occupancy and `flush_idle` against the design, so a walk that missed the new instruction, or counted the retired one, shows up as a mismatch. Sequence numbers wrap many times during the run, which exercises the signed comparison.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {
    RB_RUN  = 1'b0,
    RB_WALK = 1'b1
  } rob_mode_e;
endpackage

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [SEQ_W-1:0]              wr_seq,
  input  logic [PC_W-1:0]               wr_pc,
  input  logic [PC_W-1:0]               wr_npc,
  input  logic                          cm_en,
  input  logic [IDX_W-1:0]              cm_idx,
  input  logic [DEPTH-1:0]              kill_mask,
  input  logic [IDX_W-1:0]              hd_idx,
  input  logic [IDX_W-1:0]              tl_idx,
  output logic [SEQ_W-1:0]              hd_seq,
  output logic [PC_W-1:0]               hd_pc,
  output logic [PC_W-1:0]               hd_npc,
  output logic                          hd_cmpl,
  output logic                          hd_killed,
  output logic [SEQ_W-1:0]              tl_seq,
  output logic [PC_W-1:0]               tl_pc,
  output logic [DEPTH-1:0][SEQ_W-1:0]   seq_all
);
  logic [DEPTH-1:0][PC_W-1:0] pc_r;
  logic [DEPTH-1:0][PC_W-1:0] npc_r;
  logic [DEPTH-1:0]           cmpl_r;
  logic [DEPTH-1:0]           kill_r;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic hit_wr;
    logic hit_cm;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(s));
    assign hit_cm = cm_en && (cm_idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seq_all[s] <= '0;
        pc_r[s]    <= '0;
        npc_r[s]   <= '0;
        cmpl_r[s]  <= 1'b0;
        kill_r[s]  <= 1'b0;
      end else if (hit_wr) begin
        seq_all[s] <= wr_seq;
        pc_r[s]    <= wr_pc;
        npc_r[s]   <= wr_npc;
        cmpl_r[s]  <= 1'b0;
        kill_r[s]  <= 1'b0;
      end else begin
        if (hit_cm)       cmpl_r[s] <= 1'b1;
        if (kill_mask[s]) kill_r[s] <= 1'b1;
      end
    end
  end

  assign hd_seq    = seq_all[hd_idx];
  assign hd_pc     = pc_r[hd_idx];
  assign hd_npc    = npc_r[hd_idx];
  assign hd_cmpl   = cmpl_r[hd_idx];
  assign hd_killed = kill_r[hd_idx];
  assign tl_seq    = seq_all[tl_idx];
  assign tl_pc     = pc_r[tl_idx];
endmodule

// File: rtl/rob_walk_window.sv
module rob_walk_window #(
  parameter int DEPTH    = 16,
  parameter int SQ_WIDTH = 4,
  parameter int SEQ_W    = 16,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic [IDX_W-1:0]            walk_ptr,
  input  logic [CNT_W-1:0]            walk_left,
  input  logic [SEQ_W-1:0]            key,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_all,
  output logic [DEPTH-1:0]            kill_mask,
  output logic [CNT_W-1:0]            kill_cnt,
  output logic                        walk_stop
);
  logic [SQ_WIDTH-1:0]            run;
  logic [SQ_WIDTH-1:0][IDX_W-1:0] win_idx;

  for (genvar k = 0; k < SQ_WIDTH; k++) begin : g_win
    localparam logic [CNT_W-1:0] KPOS = CNT_W'(k);
    logic [SEQ_W-1:0] diff;
    logic             younger;
    logic             in_range;
    assign win_idx[k] = walk_ptr - IDX_W'(k);
    assign diff       = seq_all[win_idx[k]] - key;
    assign younger    = !diff[SEQ_W-1] && (diff != '0);
    assign in_range   = KPOS < walk_left;
    if (k == 0) begin : g_first
      assign run[k] = in_range && younger;
    end else begin : g_next
      assign run[k] = run[k-1] && in_range && younger;
    end
  end

  always_comb begin
    kill_mask = '0;
    kill_cnt  = '0;
    for (int k = 0; k < SQ_WIDTH; k++) begin
      if (run[k]) begin
        kill_mask[win_idx[k]] = 1'b1;
        kill_cnt = kill_cnt + 1'b1;
      end
    end
  end

  assign walk_stop = (kill_cnt < CNT_W'(SQ_WIDTH)) || (kill_cnt == walk_left);
endmodule

// File: rtl/rob_incr_squash.sv
module rob_incr_squash #(
  parameter int DEPTH    = 16,
  parameter int SQ_WIDTH = 4,
  parameter int PC_W     = 32,
  parameter int SEQ_W    = 16,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [PC_W-1:0]  in_npc,
  output logic [IDX_W-1:0] in_slot,
  output logic             in_overrun,
  input  logic             done_valid,
  input  logic [IDX_W-1:0] done_slot,
  output logic             hd_ready,
  input  logic             hd_retire,
  output logic [SEQ_W-1:0] hd_seq,
  output logic [PC_W-1:0]  hd_pc,
  output logic [PC_W-1:0]  hd_npc,
  output logic [SEQ_W-1:0] tl_seq,
  output logic [PC_W-1:0]  tl_pc,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] free_cnt,
  input  logic             flush_req,
  input  logic [SEQ_W-1:0] flush_seq,
  output logic             flush_idle
);
  import rob_pkg::*;

  localparam logic [CNT_W-1:0] CAP     = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] STEP_C  = CNT_W'(SQ_WIDTH);
  localparam logic [IDX_W-1:0] STEP_I  = IDX_W'(SQ_WIDTH);

  rob_mode_e        mode_q;
  logic [IDX_W-1:0] head_q, tail_q, walk_ptr_q;
  logic [CNT_W-1:0] occ_q, walk_left_q;
  logic [SEQ_W-1:0] key_q;

  logic             walking, ins_fire, ret_fire, flush_take;
  logic [IDX_W-1:0] tail_step;
  logic [CNT_W-1:0] occ_step;
  logic             hd_cmpl, hd_killed;
  logic [DEPTH-1:0]            kill_mask, kill_gate;
  logic [CNT_W-1:0]            kill_cnt;
  logic                        walk_stop;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_all;

  assign walking    = (mode_q == RB_WALK);
  assign full       = (occ_q == CAP);
  assign empty      = (occ_q == '0);
  assign free_cnt   = CAP - occ_q;
  assign in_ready   = !full && !walking;
  assign in_overrun = in_valid && full;
  assign in_slot    = tail_q;
  assign flush_idle = !walking;
  assign hd_ready   = !empty && hd_cmpl && !walking;

  assign ins_fire   = in_valid && in_ready;
  assign ret_fire   = hd_retire && hd_ready;
  assign flush_take = flush_req && !walking;
  assign tail_step  = tail_q + IDX_W'(ins_fire);
  assign occ_step   = occ_q + CNT_W'(ins_fire) - CNT_W'(ret_fire);
  assign kill_gate  = walking ? kill_mask : '0;

  rob_entry_store #(
    .DEPTH(DEPTH), .PC_W(PC_W), .SEQ_W(SEQ_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ins_fire),
    .wr_idx    (tail_q),
    .wr_seq    (in_seq),
    .wr_pc     (in_pc),
    .wr_npc    (in_npc),
    .cm_en     (done_valid),
    .cm_idx    (done_slot),
    .kill_mask (kill_gate),
    .hd_idx    (head_q),
    .tl_idx    (tail_q - 1'b1),
    .hd_seq    (hd_seq),
    .hd_pc     (hd_pc),
    .hd_npc    (hd_npc),
    .hd_cmpl   (hd_cmpl),
    .hd_killed (hd_killed),
    .tl_seq    (tl_seq),
    .tl_pc     (tl_pc),
    .seq_all   (seq_all)
  );

  rob_walk_window #(
    .DEPTH(DEPTH), .SQ_WIDTH(SQ_WIDTH), .SEQ_W(SEQ_W)
  ) u_walk (
    .walk_ptr  (walk_ptr_q),
    .walk_left (walk_left_q),
    .key       (key_q),
    .seq_all   (seq_all),
    .kill_mask (kill_mask),
    .kill_cnt  (kill_cnt),
    .walk_stop (walk_stop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= RB_RUN;
      head_q      <= '0;
      tail_q      <= '0;
      occ_q       <= '0;
      walk_ptr_q  <= '0;
      walk_left_q <= '0;
      key_q       <= '0;
    end else if (!walking) begin
      head_q <= head_q + IDX_W'(ret_fire);
      tail_q <= tail_step;
      occ_q  <= occ_step;
      if (flush_take) begin
        mode_q      <= RB_WALK;
        walk_ptr_q  <= tail_step - 1'b1;
        walk_left_q <= occ_step;
        key_q       <= flush_seq;
      end
    end else if (walk_stop) begin
      mode_q <= RB_RUN;
      tail_q <= walk_ptr_q - IDX_W'(kill_cnt) + 1'b1;
      occ_q  <= walk_left_q - kill_cnt;
    end else begin
      walk_ptr_q  <= walk_ptr_q - STEP_I;
      walk_left_q <= walk_left_q - STEP_C;
    end
  end
endmodule

// File: rtl/rob_incr_squash_chk.sv
module rob_incr_squash_chk #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_overrun,
  input logic             hd_ready,
  input logic             hd_retire,
  input logic             hd_killed,
  input logic [SEQ_W-1:0] tl_seq,
  input logic [PC_W-1:0]  tl_pc,
  input logic             full,
  input logic             empty,
  input logic [CNT_W-1:0] free_cnt,
  input logic             flush_req,
  input logic             flush_idle
);
  assert_free_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (free_cnt == '0));
  assert_free_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (free_cnt == CNT_W'(DEPTH)));
  assert_insert_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(hd_retire && hd_ready)) |=> (free_cnt == $past(free_cnt) - 1'b1));
  assert_retire_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_retire && hd_ready && !(in_valid && in_ready)) |=> (free_cnt == $past(free_cnt) + 1'b1));
  assert_no_ready_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);
  assert_overrun_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_overrun |-> (in_valid && !in_ready));
  assert_head_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hd_ready |-> (!empty && flush_idle && !hd_killed));
  assert_tail_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_idle |=> (flush_idle || ($stable(tl_seq) && $stable(tl_pc) && $stable(free_cnt))));
  assert_flush_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && flush_idle) |=> !flush_idle);
endmodule

bind rob_incr_squash rob_incr_squash_chk #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_overrun (in_overrun),
  .hd_ready   (hd_ready),
  .hd_retire  (hd_retire),
  .hd_killed  (hd_killed),
  .tl_seq     (tl_seq),
  .tl_pc      (tl_pc),
  .full       (full),
  .empty      (empty),
  .free_cnt   (free_cnt),
  .flush_req  (flush_req),
  .flush_idle (flush_idle)
);

// File: tb/rob_incr_squash_tb.sv
module rob_incr_squash_tb_top;
  localparam int D   = 8;
  localparam int W   = 3;
  localparam int PCW = 32;
  localparam int SW  = 8;
  localparam int IW  = $clog2(D);
  localparam int CW  = $clog2(D + 1);

  typedef struct {
    logic [SW-1:0]  seq;
    logic [PCW-1:0] pc;
    logic [PCW-1:0] npc;
    bit             done;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, hd_retire = 1'b0, done_valid = 1'b0, flush_req = 1'b0;
  logic [SW-1:0]  in_seq = '0, flush_seq = '0;
  logic [PCW-1:0] in_pc = '0, in_npc = '0;
  logic [IW-1:0]  done_slot = '0;
  logic in_ready, in_overrun, hd_ready, full, empty, flush_idle;
  logic [IW-1:0]  in_slot;
  logic [SW-1:0]  hd_seq, tl_seq;
  logic [PCW-1:0] hd_pc, hd_npc, tl_pc;
  logic [CW-1:0]  free_cnt;

  always #10 clk = ~clk;

  rob_incr_squash #(.DEPTH(D), .SQ_WIDTH(W), .PC_W(PCW), .SEQ_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_seq(in_seq), .in_pc(in_pc),
    .in_npc(in_npc), .in_slot(in_slot), .in_overrun(in_overrun),
    .done_valid(done_valid), .done_slot(done_slot),
    .hd_ready(hd_ready), .hd_retire(hd_retire),
    .hd_seq(hd_seq), .hd_pc(hd_pc), .hd_npc(hd_npc),
    .tl_seq(tl_seq), .tl_pc(tl_pc),
    .full(full), .empty(empty), .free_cnt(free_cnt),
    .flush_req(flush_req), .flush_seq(flush_seq), .flush_idle(flush_idle)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  ent_t q[$];
  int   m_hd = 0;
  bit   m_busy = 0;
  int   m_wpos = 0;
  logic [SW-1:0] m_key = '0;
  logic [SW-1:0] next_seq = 8'd200;

  function automatic bit younger(logic [SW-1:0] a, logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = a - b;
    return (d != '0) && !d[SW-1];
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    int sz;
    sz = q.size();
    chk("R1", "full", full, sz == D);
    chk("R1", "empty", empty, sz == 0);
    chk("R2", "free_cnt", free_cnt, D - sz);
    chk("R3", "in_ready", in_ready, (sz != D) && !m_busy);
    chk("R3", "in_slot", in_slot, (m_hd + sz) % D);
    chk("R4", "in_overrun", in_overrun, in_valid && (sz == D));
    chk("R6", "hd_ready", hd_ready, (sz > 0) && q[0].done && !m_busy);
    chk("R8", "flush_idle", flush_idle, !m_busy);
    if (sz > 0) begin
      chk("R5", "hd_seq", hd_seq, q[0].seq);
      chk("R5", "hd_pc", hd_pc, q[0].pc);
      chk("R5", "hd_npc", hd_npc, q[0].npc);
      chk("R10", "tl_seq", tl_seq, q[sz-1].seq);
      chk("R10", "tl_pc", tl_pc, q[sz-1].pc);
    end
  endtask

  // Behavioural model, one call per rising edge using the inputs held there.
  task automatic model_step();
    bit was_busy, rdy, hr;
    int n;
    was_busy = m_busy;
    rdy = (q.size() != D) && !m_busy;
    hr  = (q.size() > 0) && q[0].done && !m_busy;
    if (done_valid) begin
      int i;
      i = (int'(done_slot) - m_hd + D) % D;
      if (i < q.size()) q[i].done = 1;
    end
    // R12: retire and insert are applied before a same-edge flush begins
    if (hd_retire && hr) begin
      void'(q.pop_front());
      m_hd = (m_hd + 1) % D;
    end
    if (in_valid && rdy) begin
      ent_t e;
      e.seq = in_seq; e.pc = in_pc; e.npc = in_npc; e.done = 0;
      q.push_back(e);
      next_seq = next_seq + 8'(1 + ($urandom % 2));
    end
    if (!was_busy) begin
      if (flush_req) begin
        m_busy = 1;
        m_wpos = q.size() - 1;
        m_key  = flush_seq;
      end
    end else begin
      // R9, R11: up to W entries per cycle, signed-difference ordering
      n = 0;
      while (n < W && (m_wpos - n) >= 0 && younger(q[m_wpos - n].seq, m_key)) n++;
      if (n < W || (m_wpos - n) < 0) begin
        while (q.size() > m_wpos - n + 1) void'(q.pop_back());
        m_busy = 0;
      end else begin
        m_wpos = m_wpos - W;
      end
    end
  endtask

  task automatic drive(int p_ins, int p_ret, int p_fl);
    int sz;
    sz = q.size();
    in_valid = ($urandom % 100) < p_ins;
    in_seq   = next_seq;
    in_pc    = $urandom;
    in_npc   = in_pc + 32'd4;
    done_valid = (sz > 0) && (($urandom % 100) < 60);
    done_slot  = (sz > 0) ? IW'((m_hd + ($urandom % sz)) % D) : '0;
    hd_retire  = ($urandom % 100) < p_ret;
    flush_req  = ($urandom % 100) < p_fl;
    if (sz == 0) flush_seq = next_seq - 8'd1;
    else case ($urandom % 4)
      0: flush_seq = q[0].seq - 8'd1;
      1: flush_seq = q[sz-1].seq;
      default: flush_seq = q[$urandom % sz].seq;
    endcase
  endtask

  task automatic run_cycles(int n, int p_ins, int p_ret, int p_fl);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      drive(p_ins, p_ret, p_fl);
      #2;
      compare_all();
      @(posedge clk);
      model_step();
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset empty", empty, 1);
    chk("R1", "reset full", full, 0);
    chk("R1", "reset flush_idle", flush_idle, 1);
    chk("R6", "reset hd_ready", hd_ready, 0);
    chk("R2", "reset free_cnt", free_cnt, D);
    rst_n = 1'b1;
    // R3, R4: fill to capacity and push against full
    run_cycles(40, 95, 0, 0);
    // R6: drain with completions
    run_cycles(60, 0, 90, 0);
    // R7..R12: mixed traffic with frequent flushes
    run_cycles(3000, 70, 50, 8);
    // R4: full pressure with flushes
    run_cycles(1000, 95, 15, 5);
    run_cycles(2000, 50, 60, 12);
    finish_run();
  end
endmodule